// File: doc/BRIEF.md
# Latched 64-bit System Timer

This block is a memory-mapped system timer. A free-running 64-bit up-counter advances on the ticks of a programmable prescaler. Six 32-bit compare channels watch the low word of the counter. When a channel matches, it sets its bit in a sticky status register, and software clears that bit by writing a one to it. Each channel drives its own interrupt line, gated by an enable bit. The last channel also serves as a watchdog: when the watchdog is armed, a match on that channel raises a reset request.

Software cannot read a 64-bit value in one bus access without risking a torn result. A write to a capture command therefore copies the whole count into two read-only snapshot words in a single clock edge. Software may also load either counter word directly.

The bus is a plain 32-bit register port: word address, write enable, write data, and read data that is combinational from the address. Two state machines sit inside the block. The prescaler alternates between states PH_LOW and PH_HIGH, and each state lasts DIV+1 clocks. The transition out of PH_HIGH issues a tick, and a divider write forces the restart transition to PH_LOW. The watchdog sits in WD_ARMED until the BITE transition, which needs a channel-5 match while enabled, takes it to WD_BITE. The RELEASE transition returns it to WD_ARMED once the enable is zero.

Top module: `sys_timer64`

## Requirements
- R1: After reset, the counter, both snapshot words, status, interrupt enable, watchdog enable and divider read as zero, and every compare register reads 0xFFFFFFFF.
- R2: Word addresses select the registers as follows: 0 counter low, 1 counter high, 2 to 7 compare 0 to 5, 8 status, 9 interrupt enable (bits 5:0), 10 watchdog enable (bit 0), 11 divider, 12 capture command, 13 snapshot low, 14 snapshot high. Address 12 and address 15 read as zero. Writes take effect at the clock edge that samples them, and reads are combinational.
- R3: The counter advances by one every 2*(DIV+1) clocks. A divider write restarts the period at that edge, so the first tick lands on the 2*(DIV+1)-th edge after the write edge.
- R4: A write to address 0 or 1 loads that counter word and suppresses the increment for that edge. The counter wraps from all-ones to zero.
- R5: A write to address 12 with bit 0 set copies the 64-bit count as it was before that edge into the snapshot words. A write with bit 0 clear has no effect, and the snapshot words otherwise hold.
- R6: On an increment, each channel whose compare value equals the new low word sets its status bit at that same edge. This includes the wrap from 0xFFFFFFFF to 0. Counter loads never cause a match.
- R7: Writing status clears each bit written as 1 and keeps each bit written as 0. A match in the same cycle as a clear of the same bit leaves the bit set.
- R8: irq[n] is high exactly while status bit n and interrupt enable bit n are both set.
- R9: With the watchdog enabled, a channel-5 match raises wdog_rst at the match edge. wdog_rst stays high until the edge after the one that stores 0 into the watchdog enable.
- R10: With the watchdog disabled, a channel-5 match sets status bit 5 only, and wdog_rst stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the addressed register |
| irq | output | 6 | Per-channel interrupt, status AND enable |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
A read reflects the register state in the same cycle, so a written value is due one edge after the write. Counter increments and status, interrupt and watchdog assertion land on the tick edge itself. Watchdog release lands one edge after the enable is cleared. The bench model updates on each rising edge from the inputs that edge samples, and the design is compared against it at the following falling edge, so every result is checked in the cycle it is due. The directed checks count edges from the stimulus: prescaler restart, watchdog hold and release, and reset contents.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
    localparam int NCH   = 6;
    localparam int WD_CH = NCH - 1;
    localparam int AW    = 4;

    localparam logic [AW-1:0] IDX_CNT_LO  = 4'd0;
    localparam logic [AW-1:0] IDX_CNT_HI  = 4'd1;
    localparam int            IDX_CMP0    = 2;
    localparam logic [AW-1:0] IDX_STATUS  = 4'd8;
    localparam logic [AW-1:0] IDX_INTEN   = 4'd9;
    localparam logic [AW-1:0] IDX_WDEN    = 4'd10;
    localparam logic [AW-1:0] IDX_DIV     = 4'd11;
    localparam logic [AW-1:0] IDX_CAPTURE = 4'd12;
    localparam logic [AW-1:0] IDX_SNAP_LO = 4'd13;
    localparam logic [AW-1:0] IDX_SNAP_HI = 4'd14;

    typedef enum logic { PH_LOW, PH_HIGH }   ps_phase_e;
    typedef enum logic { WD_ARMED, WD_BITE } wd_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr64_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    input  logic          restart,
    output logic          tick
);
    localparam logic [DW-1:0] ONE = 1;

    ps_phase_e     ph_q, ph_d;
    logic [DW-1:0] pcnt_q, pcnt_d;
    logic          at_end;

    // next-state: each phase lasts div+1 clocks
    always_comb begin
        at_end = (pcnt_q == div);
        ph_d   = ph_q;
        pcnt_d = pcnt_q + ONE;
        if (restart) begin
            ph_d   = PH_LOW;
            pcnt_d = '0;
        end else begin
            unique case (ph_q)
                PH_LOW: begin
                    if (at_end) begin
                        ph_d   = PH_HIGH;
                        pcnt_d = '0;
                    end
                end
                PH_HIGH: begin
                    if (at_end) begin
                        ph_d   = PH_LOW;
                        pcnt_d = '0;
                    end
                end
                default: begin
                    ph_d   = PH_LOW;
                    pcnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= PH_LOW;
            pcnt_q <= '0;
        end else begin
            ph_q   <= ph_d;
            pcnt_q <= pcnt_d;
        end
    end

    // output: tick on leaving PH_HIGH
    always_comb begin
        tick = (ph_q == PH_HIGH) && at_end;
    end

    // R3: phase counter never runs past the divider
    a_r3_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= div);

    // R3: a restart always lands in PH_LOW at count zero
    a_r3_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ph_q == PH_LOW && pcnt_q == '0));
endmodule

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
    parameter int DW  = 32,
    parameter int NCH = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DW-1:0]            lo_next,
    input  logic                     step,
    input  logic [NCH-1:0]           cmp_we,
    input  logic [DW-1:0]            wr_data,
    input  logic                     clr_we,
    output logic [NCH-1:0][DW-1:0]   cmp_q,
    output logic [NCH-1:0]           status_q,
    output logic [NCH-1:0]           match
);
    logic [NCH-1:0] clr_mask;

    always_comb begin
        clr_mask = clr_we ? wr_data[NCH-1:0] : '0;
        for (int ch = 0; ch < NCH; ch++) begin
            match[ch] = step && (lo_next == cmp_q[ch]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) cmp_q[ch] <= '1;
            status_q <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (cmp_we[ch]) cmp_q[ch] <= wr_data;
            end
            status_q <= (status_q & ~clr_mask) | match;
        end
    end

    // R7: a match wins over a same-cycle clear
    a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> ((status_q & $past(match)) == $past(match)));

    // R7: clearing without a match empties the written bits
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && match == '0) |=> ((status_q & $past(clr_mask)) == '0));

    // R6: no new status bit appears without a counter step
    a_r6_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr64_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bite_req,
    input  logic arm_en,
    output logic wdog_rst
);
    wd_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_ARMED: if (bite_req && arm_en) st_d = WD_BITE;   // BITE
            WD_BITE:  if (!arm_en)            st_d = WD_ARMED;  // RELEASE
            default:                          st_d = WD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WD_ARMED;
        else        st_q <= st_d;
    end

    always_comb begin
        wdog_rst = (st_q == WD_BITE);
    end

    // R9: an enabled channel-5 match raises the reset request
    a_r9_bite: assert property (@(posedge clk) disable iff (!rst_n)
        (bite_req && arm_en) |=> wdog_rst);

    // R9: request held while still enabled
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst && arm_en) |=> wdog_rst);

    // R9: request drops once the enable is clear
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_rst && !arm_en) |=> !wdog_rst);

    // R10: disabled watchdog never starts a request
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_en && !wdog_rst) |=> !wdog_rst);
endmodule

// File: rtl/sys_timer64.sv
module sys_timer64
    import tmr64_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    output logic [NCH-1:0]    irq,
    output logic              wdog_rst
);
    localparam int            CW   = 2 * DW;
    localparam logic [CW-1:0] CONE = 1;
    localparam logic [DW-1:0] LONE = 1;

    logic [CW-1:0]          count_q, snap_q;
    logic [NCH-1:0]         inten_q;
    logic                   wden_q;
    logic [DW-1:0]          div_q;

    logic                   hit_lo, hit_hi, hit_status, hit_inten;
    logic                   hit_wden, hit_div, hit_cap;
    logic [NCH-1:0]         cmp_we;
    logic                   cnt_wr, tick, step;
    logic [DW-1:0]          lo_next;
    logic [NCH-1:0][DW-1:0] cmp_q;
    logic [NCH-1:0]         status_q, match;

    // write decode
    always_comb begin
        hit_lo     = wr_en && (addr == IDX_CNT_LO);
        hit_hi     = wr_en && (addr == IDX_CNT_HI);
        hit_status = wr_en && (addr == IDX_STATUS);
        hit_inten  = wr_en && (addr == IDX_INTEN);
        hit_wden   = wr_en && (addr == IDX_WDEN);
        hit_div    = wr_en && (addr == IDX_DIV);
        hit_cap    = wr_en && (addr == IDX_CAPTURE);
        for (int ch = 0; ch < NCH; ch++) begin
            cmp_we[ch] = wr_en && (addr == AW'(IDX_CMP0 + ch));
        end
        cnt_wr  = hit_lo || hit_hi;
        step    = tick && !cnt_wr;
        lo_next = count_q[DW-1:0] + LONE;
    end

    tmr_prescaler #(.DW(DW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div_q),
        .restart (hit_div),
        .tick    (tick)
    );

    tmr_cmp_bank #(.DW(DW), .NCH(NCH)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_next  (lo_next),
        .step     (step),
        .cmp_we   (cmp_we),
        .wr_data  (wr_data),
        .clr_we   (hit_status),
        .cmp_q    (cmp_q),
        .status_q (status_q),
        .match    (match)
    );

    tmr_wdog u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bite_req (match[WD_CH]),
        .arm_en   (wden_q),
        .wdog_rst (wdog_rst)
    );

    // counter, snapshot and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            snap_q  <= '0;
            inten_q <= '0;
            wden_q  <= 1'b0;
            div_q   <= '0;
        end else begin
            if (cnt_wr) begin
                if (hit_lo) count_q[DW-1:0]  <= wr_data;
                if (hit_hi) count_q[CW-1:DW] <= wr_data;
            end else if (tick) begin
                count_q <= count_q + CONE;
            end
            if (hit_cap && wr_data[0]) snap_q  <= count_q;
            if (hit_inten)             inten_q <= wr_data[NCH-1:0];
            if (hit_wden)              wden_q  <= wr_data[0];
            if (hit_div)               div_q   <= wr_data;
        end
    end

    // read mux
    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (addr == AW'(IDX_CMP0 + ch)) rd_data = cmp_q[ch];
        end
        case (addr)
            IDX_CNT_LO:  rd_data = count_q[DW-1:0];
            IDX_CNT_HI:  rd_data = count_q[CW-1:DW];
            IDX_STATUS:  rd_data = DW'(status_q);
            IDX_INTEN:   rd_data = DW'(inten_q);
            IDX_WDEN:    rd_data = DW'(wden_q);
            IDX_DIV:     rd_data = div_q;
            IDX_SNAP_LO: rd_data = snap_q[DW-1:0];
            IDX_SNAP_HI: rd_data = snap_q[CW-1:DW];
            default:     ;
        endcase
    end

    always_comb begin
        irq = status_q & inten_q;
    end

    // R4: a tick without a load advances the count by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (count_q == $past(count_q) + CONE));

    // R4: no tick and no load keeps the count
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count_q));

    // R5: capture copies the pre-edge count
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cap && wr_data[0]) |=> (snap_q == $past(count_q)));

    // R5: snapshot holds without a capture command
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_cap && wr_data[0]) |=> $stable(snap_q));
endmodule

// File: tb/tb_sys_timer64.sv
`timescale 1ns/1ps
module tb_sys_timer64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [5:0]  irq;
    logic        wdog_rst;

    int vectors = 0;
    int fails   = 0;

    always #2.5 clk = ~clk;

    sys_timer64 dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq      (irq),
        .wdog_rst (wdog_rst)
    );

    // behavioural reference model
    logic [63:0] m_cnt = '0;
    logic [63:0] m_snap = '0;
    logic [31:0] m_cmp [6];
    logic [5:0]  m_stat = '0;
    logic [5:0]  m_inten = '0;
    logic        m_wden = 1'b0;
    logic        m_bite = 1'b0;
    logic [31:0] m_div = '0;
    longint      m_pre = 0;

    always @(posedge clk) begin : model
        logic        tk;
        logic        cwr;
        logic [5:0]  mt;
        logic [31:0] nlo;
        longint      period;
        if (!rst_n) begin
            m_cnt = '0; m_snap = '0; m_stat = '0; m_inten = '0;
            m_wden = 1'b0; m_bite = 1'b0; m_div = '0; m_pre = 0;
            for (int i = 0; i < 6; i++) m_cmp[i] = 32'hFFFF_FFFF;
        end else begin
            period = 2 * (longint'(m_div) + 1);
            tk  = (m_pre == period - 1);
            cwr = wr_en && (addr == 4'd0 || addr == 4'd1);
            nlo = m_cnt[31:0] + 32'd1;
            mt  = '0;
            if (tk && !cwr)
                for (int i = 0; i < 6; i++) if (nlo == m_cmp[i]) mt[i] = 1'b1;
            if (!m_bite && mt[5] && m_wden) m_bite = 1'b1;
            else if (m_bite && !m_wden)     m_bite = 1'b0;
            if (wr_en && addr == 4'd8) m_stat = m_stat & ~wr_data[5:0];
            m_stat = m_stat | mt;
            if (wr_en && addr == 4'd12 && wr_data[0]) m_snap = m_cnt;
            if (cwr) begin
                if (addr == 4'd0) m_cnt[31:0]  = wr_data;
                else              m_cnt[63:32] = wr_data;
            end else if (tk) begin
                m_cnt = m_cnt + 64'd1;
            end
            if (wr_en && addr >= 4'd2 && addr <= 4'd7) m_cmp[addr - 4'd2] = wr_data;
            if (wr_en && addr == 4'd9)  m_inten = wr_data[5:0];
            if (wr_en && addr == 4'd10) m_wden  = wr_data[0];
            if (wr_en && addr == 4'd11) m_div   = wr_data;
            if (wr_en && addr == 4'd11) m_pre = 0;
            else if (tk)                m_pre = 0;
            else                        m_pre = m_pre + 1;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0:  return m_cnt[31:0];
            4'd1:  return m_cnt[63:32];
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return m_cmp[a - 4'd2];
            4'd8:  return {26'd0, m_stat};
            4'd9:  return {26'd0, m_inten};
            4'd10: return {31'd0, m_wden};
            4'd11: return m_div;
            4'd13: return m_snap[31:0];
            4'd14: return m_snap[63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        case (a)
            4'd0, 4'd1:   return "R4";
            4'd8:         return "R7";
            4'd13, 4'd14: return "R5";
            default:      return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check(req_of(addr), 64'(rd_data), 64'(exp_rd(addr)));
        check("R8", 64'(irq), 64'(m_stat & m_inten));
        check("R9", 64'(wdog_rst), 64'(m_bite));
    endtask

    task automatic step(input logic [3:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        compare_all();
        addr = a; wr_en = we; wr_data = d;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        for (int i = 0; i < n; i++) step(a, 1'b0, 32'd0);
    endtask

    // explicit check just after a step has applied its inputs
    task automatic now_check(input string req, input logic [63:0] act_sel, input logic [63:0] exp);
        check(req, act_sel, exp);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] tgt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        step(4'd2, 1'b0, 0);  #1 now_check("R1", 64'(rd_data), 64'hFFFF_FFFF);
        step(4'd7, 1'b0, 0);  #1 now_check("R1", 64'(rd_data), 64'hFFFF_FFFF);
        step(4'd8, 1'b0, 0);  #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd9, 1'b0, 0);  #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd10, 1'b0, 0); #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd11, 1'b0, 0); #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd13, 1'b0, 0); #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd14, 1'b0, 0); #1 now_check("R1", 64'(rd_data), 64'd0);
        step(4'd12, 1'b0, 0); #1 now_check("R2", 64'(rd_data), 64'd0);
        step(4'd15, 1'b0, 0); #1 now_check("R2", 64'(rd_data), 64'd0);
        #1 now_check("R10", 64'(wdog_rst), 64'd0);

        // R3: divider 2 gives a 6-clock period, restarted by the write
        step(4'd11, 1'b1, 32'd2);
        step(4'd0, 1'b1, 32'd0);
        idle(5, 4'd0);  #1 now_check("R3", 64'(rd_data), 64'd0);
        idle(6, 4'd0);  #1 now_check("R3", 64'(rd_data), 64'd1);
        idle(1, 4'd0);  #1 now_check("R3", 64'(rd_data), 64'd2);
        idle(20, 4'd0);

        // R4: load both words, watch the count
        step(4'd0, 1'b1, 32'd100);
        step(4'd1, 1'b1, 32'h0000_0042);
        idle(30, 4'd1);
        idle(10, 4'd0);

        // R5: capture, then a command with bit 0 clear
        step(4'd12, 1'b1, 32'd1);
        step(4'd13, 1'b0, 0);
        step(4'd14, 1'b0, 0);
        idle(15, 4'd0);
        step(4'd12, 1'b1, 32'd2);
        step(4'd13, 1'b0, 0);
        step(4'd14, 1'b0, 0);
        step(4'd1, 1'b1, 32'h1234_5678);
        step(4'd12, 1'b1, 32'd1);
        idle(3, 4'd14);
        idle(3, 4'd13);

        // R6/R8: compare 0 match and interrupt
        step(4'd9, 1'b1, 32'h01);
        tgt = m_cnt[31:0] + 32'd3;
        step(4'd2, 1'b1, tgt);
        idle(30, 4'd8);
        #1 now_check("R6", 64'(rd_data[0]), 64'd1);
        now_check("R8", 64'(irq[0]), 64'd1);
        // R7: clear with zero keeps, with one clears
        step(4'd8, 1'b1, 32'h0);
        step(4'd8, 1'b1, 32'h1);
        idle(3, 4'd8);
        #1 now_check("R7", 64'(rd_data[0]), 64'd0);

        // R7: match during continuous clears
        step(4'd11, 1'b1, 32'd0);
        tgt = m_cnt[31:0] + 32'd3;
        step(4'd3, 1'b1, tgt);
        step(4'd9, 1'b1, 32'h3F);
        for (int i = 0; i < 14; i++) step(4'd8, 1'b1, 32'h3F);
        idle(2, 4'd8);

        // R6/R4: match on the wrap of the low word
        step(4'd4, 1'b1, 32'd0);
        step(4'd0, 1'b1, 32'hFFFF_FFFD);
        step(4'd1, 1'b1, 32'd5);
        idle(12, 4'd0);
        step(4'd1, 1'b0, 0); #1 now_check("R4", 64'(rd_data), 64'd6);
        step(4'd8, 1'b0, 0); #1 now_check("R6", 64'(rd_data[2]), 64'd1);

        // R10: watchdog disabled
        step(4'd8, 1'b1, 32'h3F);
        tgt = m_cnt[31:0] + 32'd4;
        step(4'd7, 1'b1, tgt);
        idle(15, 4'd8);
        #1 now_check("R10", 64'(rd_data[5]), 64'd1);
        now_check("R10", 64'(wdog_rst), 64'd0);

        // R9: watchdog enabled, hold and release
        step(4'd8, 1'b1, 32'h3F);
        step(4'd10, 1'b1, 32'd1);
        tgt = m_cnt[31:0] + 32'd4;
        step(4'd7, 1'b1, tgt);
        idle(15, 4'd10);
        #1 now_check("R9", 64'(wdog_rst), 64'd1);
        step(4'd8, 1'b1, 32'h3F);
        idle(5, 4'd10);
        #1 now_check("R9", 64'(wdog_rst), 64'd1);
        step(4'd10, 1'b1, 32'd0); #1 now_check("R9", 64'(wdog_rst), 64'd1);
        step(4'd10, 1'b0, 0);     #1 now_check("R9", 64'(wdog_rst), 64'd1);
        step(4'd10, 1'b0, 0);     #1 now_check("R9", 64'(wdog_rst), 64'd0);

        // R4: back-to-back loads hold off increments
        for (int i = 0; i < 8; i++) step(4'd0, 1'b1, 32'd500);
        idle(4, 4'd0);

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic        we;
            logic [31:0] d;
            a  = 4'($urandom_range(0, 15));
            we = ($urandom_range(0, 2) == 0);
            d  = $urandom;
            if (a == 4'd11) d = d & 32'd3;
            if (a >= 4'd2 && a <= 4'd7 && $urandom_range(0, 1) == 1)
                d = m_cnt[31:0] + 32'($urandom_range(1, 8));
            if ((a == 4'd0 || a == 4'd1) && $urandom_range(0, 3) != 0) we = 1'b0;
            step(a, we, d);
        end
        idle(4, 4'd8);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule